// File: doc/BRIEF.md
# Bipolar Line Code Decoder with Violation Flagging

This block sits behind clock recovery on a coaxial line receiver. Each clock it may take one received symbol as a pair of rail bits: one rail for a positive pulse, the other for a negative pulse. In the two bipolar modes it turns the symbol stream back into NRZ data. It removes the zero-substitution codes the transmitter inserted: three-zero substitution for the DS3 and STS-1 rates, four-zero substitution for the E3 rate. It also raises a one-bit flag on any output bit whose symbol broke the coding rules. In single-rail mode the positive rail carries NRZ data directly, and the block only delays it.

Both substitution codes share one datapath. The datapath is a four-stage symbol window that moves one stage for each accepted symbol. A violation pulse that completes a legal pattern erases the pulses of that pattern while they are still inside the window. Because of this the output trails the input by four accepted symbols. Input and output are valid/ready streams. The block accepts a symbol when `in_valid` and `in_ready` are both high. `in_ready` drops only while a result waits at the output with `out_ready` low. While it waits, that result holds steady and nothing inside the block moves. A downstream stall therefore stalls the line side without losing a symbol.

Top module: `bipolar_line_decoder`

## Requirements
- R1: The decoded bit of the k-th symbol accepted after reset appears on `out_data`, with `out_valid` high, at the same edge that accepts symbol k+4. Before the fifth symbol is accepted, `out_valid` stays low.
- R2: With `cfg_mode` equal to 0 or 3 (single-rail), `out_data` equals the `in_pos` value of the symbol, `in_neg` is ignored, and `out_lcv` stays low.
- R3: With `cfg_mode` equal to 1 (three-zero substitution) or 2 (four-zero substitution), a symbol with exactly one rail high decodes to 1 when its polarity is opposite to the last pulse. A symbol with both rails low decodes to 0.
- R4: In mode 1, a pulse with the same polarity as the last pulse, directly preceded by a zero symbol, completes a substitution. That pulse and the symbol two places earlier both decode to 0, and no flag is raised.
- R5: In mode 2, a same-polarity pulse directly preceded by two zero symbols completes a substitution. That pulse and the symbol three places earlier both decode to 0, and no flag is raised.
- R6: In a bipolar mode, a same-polarity pulse that does not complete the mode's pattern decodes to 1 and sets `out_lcv` on its bit.
- R7: In a bipolar mode, the zero that brings a zero run to 3 (mode 1) or 4 (mode 2) sets `out_lcv` on its bit, and so does every further zero of that run.
- R8: In a bipolar mode, a symbol with both rails high decodes to 1 and sets `out_lcv`. It ends a zero run and leaves the polarity history unchanged.
- R9: `out_lcv` is high only together with `out_valid`, and it belongs to the bit shown on `out_data`.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`/`out_lcv` hold. When `out_valid` is low, `in_ready` is high. When `out_ready` is high and no symbol is accepted, `out_valid` falls at the next edge.
- R11: Reset (`rst_n` low) clears `out_valid`, empties the window, clears the zero-run count and forgets the last polarity, so the first pulse after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0/3 single-rail, 1 three-zero code, 2 four-zero code; change only in reset |
| in_valid | input | 1 | Symbol present on the rails |
| in_ready | output | 1 | Block can take a symbol this cycle |
| in_pos | input | 1 | Positive-pulse rail (NRZ data in single-rail mode) |
| in_neg | input | 1 | Negative-pulse rail |
| out_valid | output | 1 | Decoded bit present |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_data | output | 1 | Decoded NRZ bit |
| out_lcv | output | 1 | Line-code violation on this bit |

## Verification
A single stream in the three-zero mode contains several cases: plain alternating marks, both substitution shapes, a stray violation after a mark, a four-zero run and a double-rail symbol. This tells a correct erase of the earlier pulse apart from an erase of the wrong window stage. The four-zero stream reuses the shapes that would be legal three-zero substitutions, and a three-zero run there must stay unflagged, so the mode-dependent span and run limit are both pinned. A single-rail stream with noise on the negative rail and long zero runs shows that the bypass really ignores the codec. Directed runs show that reset clears history and that a stall holds the output.

// File: rtl/bld_pkg.sv
package bld_pkg;
  typedef enum logic [1:0] {
    LM_NRZ  = 2'd0,
    LM_B3ZS = 2'd1,
    LM_HDB3 = 2'd2,
    LM_RSVD = 2'd3
  } line_mode_e;
endpackage

// File: rtl/bld_classify.sv
module bld_classify
  import bld_pkg::*;
#(
  parameter int unsigned SPAN_SHORT = 3,
  parameter int unsigned SPAN_LONG  = 4,
  parameter int unsigned DEPTH      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_mode_e       mode,
  input  logic             step,
  input  logic             sym_p,
  input  logic             sym_n,
  input  logic [DEPTH-1:0] win_zero,
  output logic             dec_mark,
  output logic             sym_zero,
  output logic             lcv_hit,
  output logic [DEPTH-1:0] clr_mask
);
  localparam int unsigned RUN_W = $clog2(SPAN_LONG + 1);

  logic             pol_q, have_pol_q;
  logic [RUN_W-1:0] run_q, run_nxt;
  logic             codec_on, is_long, pulse, both, is_v, shape_ok, sub_hit;
  logic             exz, bpv;
  int unsigned      span;

  always_comb begin
    codec_on = (mode == LM_B3ZS) || (mode == LM_HDB3);
    is_long  = (mode == LM_HDB3);
    span     = is_long ? SPAN_LONG : SPAN_SHORT;
    pulse    = sym_p ^ sym_n;
    both     = sym_p & sym_n;
    sym_zero = ~sym_p & ~sym_n;
    is_v     = pulse && have_pol_q && (sym_p == pol_q);
    shape_ok = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if ((k + 2 < span) && !win_zero[k]) shape_ok = 1'b0;
    end
    sub_hit = codec_on && is_v && shape_ok;
    bpv     = codec_on && ((is_v && !shape_ok) || both);
    if (!sym_zero)                           run_nxt = '0;
    else if (run_q == RUN_W'(SPAN_LONG))     run_nxt = run_q;
    else                                     run_nxt = run_q + 1'b1;
    exz      = codec_on && sym_zero && (32'(run_nxt) >= span);
    lcv_hit  = bpv || exz;
    dec_mark = codec_on ? ((pulse || both) && !sub_hit) : sym_p;
    for (int k = 0; k < DEPTH; k++) begin
      clr_mask[k] = sub_hit && (k + 2 == span);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q      <= 1'b0;
      have_pol_q <= 1'b0;
      run_q      <= '0;
    end else if (step) begin
      run_q <= run_nxt;
      if (pulse) begin
        pol_q      <= sym_p;
        have_pol_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bld_window.sv
module bld_window #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             in_mark,
  input  logic             in_zero,
  input  logic             in_lcv,
  input  logic [DEPTH-1:0] clr_mask,
  output logic [DEPTH-1:0] win_zero,
  output logic             head_mark,
  output logic             head_lcv,
  output logic             full
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mark_q, zero_q, lcv_q;
  logic [CNT_W-1:0] fill_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mark_q[g] <= 1'b0;
          zero_q[g] <= 1'b0;
          lcv_q[g]  <= 1'b0;
        end else if (step) begin
          mark_q[g] <= in_mark;
          zero_q[g] <= in_zero;
          lcv_q[g]  <= in_lcv;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mark_q[g] <= 1'b0;
          zero_q[g] <= 1'b0;
          lcv_q[g]  <= 1'b0;
        end else if (step) begin
          mark_q[g] <= mark_q[g-1] & ~clr_mask[g-1];
          zero_q[g] <= zero_q[g-1];
          lcv_q[g]  <= lcv_q[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                fill_q <= '0;
    else if (step && fill_q != CNT_W'(DEPTH))  fill_q <= fill_q + 1'b1;
  end

  assign win_zero  = zero_q;
  assign head_mark = mark_q[DEPTH-1];
  assign head_lcv  = lcv_q[DEPTH-1];
  assign full      = (fill_q == CNT_W'(DEPTH));
endmodule

// File: rtl/bld_out_stage.sv
module bld_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic emit,
  input  logic emit_data,
  input  logic emit_lcv,
  input  logic out_ready,
  output logic out_valid,
  output logic out_data,
  output logic out_lcv,
  output logic in_ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_lcv   <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= emit_data;
      out_lcv   <= emit_lcv;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_lcv   <= 1'b0;
    end
  end

  assign in_ready = !out_valid || out_ready;
endmodule

// File: rtl/bipolar_line_decoder.sv
module bipolar_line_decoder
  import bld_pkg::*;
#(
  parameter int unsigned SPAN_SHORT = 3,
  parameter int unsigned SPAN_LONG  = 4,
  parameter int unsigned DEPTH      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_pos,
  input  logic       in_neg,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_data,
  output logic       out_lcv
);
  line_mode_e       mode;
  logic             accept, emit, full;
  logic             dec_mark, sym_zero, lcv_hit, head_mark, head_lcv;
  logic [DEPTH-1:0] win_zero, clr_mask;

  assign mode   = line_mode_e'(cfg_mode);
  assign accept = in_valid && in_ready;
  assign emit   = accept && full;

  bld_classify #(
    .SPAN_SHORT(SPAN_SHORT), .SPAN_LONG(SPAN_LONG), .DEPTH(DEPTH)
  ) u_class (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step(accept),
    .sym_p(in_pos), .sym_n(in_neg), .win_zero(win_zero),
    .dec_mark(dec_mark), .sym_zero(sym_zero), .lcv_hit(lcv_hit),
    .clr_mask(clr_mask)
  );

  bld_window #(.DEPTH(DEPTH)) u_win (
    .clk(clk), .rst_n(rst_n), .step(accept),
    .in_mark(dec_mark), .in_zero(sym_zero), .in_lcv(lcv_hit),
    .clr_mask(clr_mask), .win_zero(win_zero),
    .head_mark(head_mark), .head_lcv(head_lcv), .full(full)
  );

  bld_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .emit(emit),
    .emit_data(head_mark), .emit_lcv(head_lcv), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_lcv(out_lcv),
    .in_ready(in_ready)
  );
endmodule

// File: rtl/bld_checker.sv
module bld_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_data,
  input logic       out_lcv
);
  p_lcv_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_lcv |-> out_valid);

  p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_lcv)));

  p_stall_blocks_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_bypass_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0 || cfg_mode == 2'd3) |-> !out_lcv);
endmodule

bind bipolar_line_decoder bld_checker u_chk (.*);

// File: tb/sim_bipolar_line_decoder.sv
`timescale 1ns/1ps
module sim_bipolar_line_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd1;
  logic       in_valid = 1'b0, in_pos = 1'b0, in_neg = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_data, out_lcv;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bipolar_line_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_pos(in_pos), .in_neg(in_neg),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_lcv(out_lcv)
  );

  // entry = {checked, pos, neg, expected data, expected lcv}
  localparam logic [4:0] TBL [64] = '{
    // three-zero code, mode 1: R3 R4 R6 R7 R8
    5'b1_10_10, 5'b1_01_10, 5'b1_00_00, 5'b1_10_10,
    5'b1_00_00, 5'b1_00_00, 5'b1_10_00, 5'b1_01_00,
    5'b1_00_00, 5'b1_01_00, 5'b1_10_10, 5'b1_10_11,
    5'b1_01_10, 5'b1_00_00, 5'b1_00_00, 5'b1_00_01,
    5'b1_00_01, 5'b1_10_10, 5'b1_11_11, 5'b1_01_10,
    5'b0_00_00, 5'b0_00_00, 5'b0_00_00, 5'b0_00_00,
    // four-zero code, mode 2: R3 R5 R6 R7
    5'b1_10_10, 5'b1_00_00, 5'b1_00_00, 5'b1_00_00,
    5'b1_10_00, 5'b1_01_10, 5'b1_10_00, 5'b1_00_00,
    5'b1_00_00, 5'b1_10_00, 5'b1_01_10, 5'b1_00_00,
    5'b1_01_11, 5'b1_10_10, 5'b1_00_00, 5'b1_00_00,
    5'b1_00_00, 5'b1_00_01, 5'b1_00_01, 5'b1_01_10,
    5'b0_00_00, 5'b0_00_00, 5'b0_00_00, 5'b0_00_00,
    // single-rail, mode 0: R2
    5'b1_10_10, 5'b1_01_00, 5'b1_00_00, 5'b1_00_00,
    5'b1_00_00, 5'b1_11_10, 5'b1_10_10, 5'b1_01_00,
    5'b1_11_10, 5'b1_00_00, 5'b1_00_00, 5'b1_10_10,
    5'b0_00_00, 5'b0_00_00, 5'b0_00_00, 5'b0_00_00
  };

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic p, input logic n);
    @(negedge clk);
    in_valid = 1'b1; in_pos = p; in_neg = n;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tag;
    int    base;
    // table walk
    for (int i = 0; i < 64; i++) begin
      if (i == 0)  begin cfg_mode = 2'd1; do_reset(); end
      if (i == 24) begin cfg_mode = 2'd2; do_reset(); end
      if (i == 48) begin cfg_mode = 2'd0; do_reset(); end
      base = (i < 24) ? 0 : (i < 48) ? 24 : 48;
      tag  = (i < 24) ? "R1 R3 R4 R6 R7 R8 R9 mode1" :
             (i < 48) ? "R1 R3 R5 R6 R7 R9 mode2" : "R1 R2 single-rail";
      send(TBL[i][3], TBL[i][2]);
      if (i - base < 4)
        check("R1 latency fill", int'(out_valid), 0);
      else if (TBL[i-4][4])
        check(tag, int'({out_valid, out_data, out_lcv}), int'({1'b1, TBL[i-4][1:0]}));
    end

    // R11: reset state
    cfg_mode = 2'd1;
    do_reset();
    #1;
    check("R11 reset state", int'({out_valid, in_ready}), 2'b01);

    // R11: history cleared (last polarity positive, zero run 2 before reset)
    send(1, 0); send(0, 0); send(0, 0);
    do_reset();
    send(0, 0); send(1, 0); send(0, 1); send(1, 0); send(0, 1);
    check("R11 zero run cleared", int'({out_valid, out_data, out_lcv}), 3'b100);

    // R10: stall holds output and blocks input
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_pos = 1'b1; in_neg = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check("R10 stall hold", int'({in_ready, out_valid, out_data, out_lcv}), 4'b0100);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R11 first pulse not violation", int'({out_valid, out_data, out_lcv}), 3'b110);
    @(posedge clk); #1;
    check("R10 valid drops when drained", int'({out_valid, in_ready}), 2'b01);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule